// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Unit

This unit holds two pending-interrupt flags for each processor in a small multiprocessor: one for interprocessor messages and one for the interval timer. Software changes the flags through four registers. A shared control register carries request and clear fields. A dedicated request register posts messages. Two status registers return the pending masks when read and clear the selected flags when written. A periodic tick input raises the timer flag on every processor that is present.

Each processor gets two level interrupt outputs that follow its flags directly. Some requests have no effect: posting a message that is already pending, or clearing one that is idle. These are reported on a one-cycle warning pulse. Malformed writes are reported on a one-cycle error pulse. The number of processors present is a parameter, from 1 to 4. Mask bits for processors that are not present are ignored.

Top module: `ipi_timer_intr_unit`

## Requirements
- R1: After reset, all interprocessor and timer flags are zero, the interrupt outputs `ipi_irq` and `tmr_irq` are low, and `warn_pulse`, `err_pulse` and `rd_valid` are low.
- R2: A control register write (`req_addr`=0) sets the interprocessor flag of processor i when bit 12+i of the write data is 1. The new level appears on `ipi_irq` right after the clock edge that accepts the write.
- R3: In a control register write, bit 8+i clears the interprocessor flag of processor i and bit 4+i clears its timer flag. If one write both requests and clears the same processor, the clear wins.
- R4: A write to the request register (`req_addr`=3) posts interprocessor flags for the mask in data bits 3:0. A write to the interprocessor status register (`req_addr`=1) clears the interprocessor flags in bits 3:0. A write to the timer status register (`req_addr`=2) clears the timer flags in bits 3:0.
- R5: When `tick` is high, every present processor's timer flag is set. If a timer clear arrives in the same cycle, the tick wins.
- R6: Posting to a processor whose interprocessor flag is already set, or clearing a flag that is idle (and not requested in the same write), leaves every flag unchanged and raises `warn_pulse` for exactly the one cycle after the write.
- R7: Some writes raise `err_pulse` for the one cycle after the write and change no flag: a control write whose bits 15:4 are all zero and whose bit 28 is clear, or a write to register 1, 2 or 3 with data bits 3:0 all zero. A control write with only bit 28 set changes nothing and is not an error.
- R8: A read (`req_valid`=1, `req_write`=0) gives `rd_valid` one cycle later, with `rd_data` taken from the flags as they stood before that edge. Register 0 returns the interprocessor mask in bits 11:8, the timer mask in bits 7:4 and `req_cpu` in bits 1:0. Register 1 returns the interprocessor mask in bits 3:0. Register 2 returns the timer mask in bits 3:0. Register 3 reads as zero. All other bits read as zero.
- R9: Mask bits for processors with index NUM_CPUS or above set and clear nothing. A write that carries only such bits changes no flag and raises no warning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select: 0 control, 1 interprocessor status, 2 timer status, 3 interprocessor request |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Identity of the processor making the access |
| tick | input | 1 | Periodic timer tick |
| ipi_irq | output | NUM_CPUS | Interprocessor interrupt level per processor |
| tmr_irq | output | NUM_CPUS | Timer interrupt level per processor |
| warn_pulse | output | 1 | No-effect request reported |
| err_pulse | output | 1 | Malformed write reported |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Every result is due one clock edge after the cycle that carries its stimulus. This covers flag levels on the interrupt outputs, both status pulses, and read data together with `rd_valid`. The bench drives each stimulus on a falling edge. In the same step it computes the expected outputs from a behavioural model. It then compares them at the next falling edge, one full edge after the one that registers them. An idle cycle follows each sequence so the last result is still compared.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  localparam int unsigned MAX_CPUS  = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned IPI_REQ_LSB = 12;
  localparam int unsigned IPI_CLR_LSB = 8;
  localparam int unsigned TMR_CLR_LSB = 4;
  localparam int unsigned NXM_ACK_BIT = 28;
  localparam int unsigned CPU_ID_W  = 2;

  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_IPI_STAT = 2'd1,
    REG_TMR_STAT = 2'd2,
    REG_IPI_REQ  = 2'd3
  } ipu_reg_e;
endpackage

// File: rtl/ipu_write_decode.sv
module ipu_write_decode
  import ipu_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CPUS-1:0] ipi_set,
  output logic [NUM_CPUS-1:0] ipi_clr,
  output logic [NUM_CPUS-1:0] tmr_clr,
  output logic              bad_write
);
  ipu_reg_e sel;
  logic [MAX_CPUS-1:0] f_req, f_clr, f_tclr, f_low;

  assign sel    = ipu_reg_e'(addr);
  assign f_req  = wdata[IPI_REQ_LSB +: MAX_CPUS];
  assign f_clr  = wdata[IPI_CLR_LSB +: MAX_CPUS];
  assign f_tclr = wdata[TMR_CLR_LSB +: MAX_CPUS];
  assign f_low  = wdata[0 +: MAX_CPUS];

  always_comb begin
    ipi_set   = '0;
    ipi_clr   = '0;
    tmr_clr   = '0;
    bad_write = 1'b0;
    if (wr_en) begin
      unique case (sel)
        REG_CTRL: begin
          ipi_set = f_req[NUM_CPUS-1:0];
          ipi_clr = f_clr[NUM_CPUS-1:0];
          tmr_clr = f_tclr[NUM_CPUS-1:0];
          bad_write = (f_req == '0) && (f_clr == '0) && (f_tclr == '0)
                      && !wdata[NXM_ACK_BIT];
        end
        REG_IPI_STAT: begin
          ipi_clr   = f_low[NUM_CPUS-1:0];
          bad_write = (f_low == '0);
        end
        REG_TMR_STAT: begin
          tmr_clr   = f_low[NUM_CPUS-1:0];
          bad_write = (f_low == '0);
        end
        REG_IPI_REQ: begin
          ipi_set   = f_low[NUM_CPUS-1:0];
          bad_write = (f_low == '0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipu_flag_bank.sv
module ipu_flag_bank #(
  parameter int unsigned N          = 4,
  parameter bit          SET_WINS   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_next;
  logic         upd_en;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb q_next = (q & ~clr) | set;
    end else begin : g_clr_wins
      always_comb q_next = (q | set) & ~clr;
    end
  endgenerate

  assign upd_en = |{set, clr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= q_next;
  end

  // R1/R2: flags only move when a set or clear is presented
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && clr == '0) |=> $stable(q));
endmodule

// File: rtl/ipu_readback.sv
module ipu_readback
  import ipu_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [1:0]          addr,
  input  logic [CPU_ID_W-1:0] cpu,
  input  logic [NUM_CPUS-1:0] ipi,
  input  logic [NUM_CPUS-1:0] tmr,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] data_next;

  always_comb begin
    data_next = '0;
    unique case (ipu_reg_e'(addr))
      REG_CTRL: begin
        data_next[IPI_CLR_LSB +: NUM_CPUS] = ipi;
        data_next[TMR_CLR_LSB +: NUM_CPUS] = tmr;
        data_next[0 +: CPU_ID_W]           = cpu;
      end
      REG_IPI_STAT: data_next[0 +: NUM_CPUS] = ipi;
      REG_TMR_STAT: data_next[0 +: NUM_CPUS] = tmr;
      default:      data_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= data_next;
  end

  // R8: read data is valid exactly one cycle after a read request
  p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/ipi_timer_intr_unit.sv
module ipi_timer_intr_unit
  import ipu_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_addr,
  input  logic [31:0]         req_wdata,
  input  logic [1:0]          req_cpu,
  input  logic                tick,
  output logic [NUM_CPUS-1:0] ipi_irq,
  output logic [NUM_CPUS-1:0] tmr_irq,
  output logic                warn_pulse,
  output logic                err_pulse,
  output logic                rd_valid,
  output logic [31:0]         rd_data
);
  logic                wr_en, rd_en;
  logic [NUM_CPUS-1:0] ipi_set, ipi_clr, tmr_clr, tmr_set;
  logic [NUM_CPUS-1:0] ipi_q, tmr_q;
  logic                bad_write, noeffect, warn_next, err_next;

  assign wr_en   = req_valid &&  req_write;
  assign rd_en   = req_valid && !req_write;
  assign tmr_set = {NUM_CPUS{tick}};

  ipu_write_decode #(.NUM_CPUS(NUM_CPUS)) u_dec (
    .wr_en     (wr_en),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .ipi_set   (ipi_set),
    .ipi_clr   (ipi_clr),
    .tmr_clr   (tmr_clr),
    .bad_write (bad_write)
  );

  ipu_flag_bank #(.N(NUM_CPUS), .SET_WINS(1'b0)) u_ipi (
    .clk (clk), .rst_n (rst_n), .set (ipi_set), .clr (ipi_clr), .q (ipi_q)
  );

  ipu_flag_bank #(.N(NUM_CPUS), .SET_WINS(1'b1)) u_tmr (
    .clk (clk), .rst_n (rst_n), .set (tmr_set), .clr (tmr_clr), .q (tmr_q)
  );

  ipu_readback #(.NUM_CPUS(NUM_CPUS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (req_addr),
    .cpu      (req_cpu),
    .ipi      (ipi_q),
    .tmr      (tmr_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // a request to a pending flag, or a clear of an idle one not requested now
  assign noeffect  = |((ipi_set & ipi_q) | (ipi_clr & ~(ipi_q | ipi_set)));
  assign warn_next = noeffect;
  assign err_next  = bad_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      warn_pulse <= warn_next;
      err_pulse  <= err_next;
    end
  end

  assign ipi_irq = ipi_q;
  assign tmr_irq = tmr_q;

  // R5: a tick leaves every present timer line high
  p_tick_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (&tmr_irq));
  // R4: dedicated request for processor 0 raises its line
  p_req_posts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd3 && req_wdata[0]) |=> ipi_irq[0]);
  // R3: clear wins over a request in the same control write
  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd0 && req_wdata[12] && req_wdata[8])
    |=> !ipi_irq[0]);
  // R7: an error pulse always follows a write
  p_err_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid && req_write));
  // R6: a warning always follows a write
  p_warn_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> $past(req_valid && req_write));
endmodule

// File: tb/ipi_timer_intr_unit_tb.sv
module ipi_timer_intr_unit_tb_top;
  localparam int N = 3;
  localparam int PMASK = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, tick;
  logic [1:0] req_addr, req_cpu;
  logic [31:0] req_wdata;
  logic [N-1:0] ipi_irq, tmr_irq;
  logic warn_pulse, err_pulse, rd_valid;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state and pending expectations
  int m_ipi = 0, m_tmr = 0;
  int e_ipi = 0, e_tmr = 0, e_warn = 0, e_err = 0, e_rdv = 0;
  int unsigned e_rdd = 0;
  string e_tag = "R1";

  always #2 clk = ~clk;

  ipi_timer_intr_unit #(.NUM_CPUS(N)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_cpu (req_cpu),
    .tick (tick), .ipi_irq (ipi_irq), .tmr_irq (tmr_irq),
    .warn_pulse (warn_pulse), .err_pulse (err_pulse),
    .rd_valid (rd_valid), .rd_data (rd_data)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "ipi_irq", int'(ipi_irq), e_ipi);
    chk(e_tag, "tmr_irq", int'(tmr_irq), e_tmr);
    chk(e_tag, "warn_pulse", int'(warn_pulse), e_warn);
    chk(e_tag, "err_pulse", int'(err_pulse), e_err);
    chk(e_tag, "rd_valid", int'(rd_valid), e_rdv);
    if (e_rdv != 0) chk(e_tag, "rd_data", int'(rd_data), int'(e_rdd));
  endtask

  task automatic step(input string tag, input bit v, input bit w, input int a,
                      input int unsigned d, input int c, input bit t);
    int s, k, tk, low;
    bit er;
    @(negedge clk);
    compare();
    req_valid = v; req_write = w; req_addr = a[1:0];
    req_wdata = d; req_cpu = c[1:0]; tick = t;
    s = 0; k = 0; tk = 0; er = 0;
    low = int'(d & 32'hF);
    e_rdv = 0;
    if (v && w) begin
      case (a)
        0: begin
          s = (d >> 12) & 15; k = (d >> 8) & 15; tk = (d >> 4) & 15;
          er = (s == 0 && k == 0 && tk == 0 && ((d >> 28) & 1) == 0);
        end
        1: begin k = low;  er = (low == 0); end
        2: begin tk = low; er = (low == 0); end
        default: begin s = low; er = (low == 0); end
      endcase
    end
    s &= PMASK; k &= PMASK; tk &= PMASK;
    e_warn = (((s & m_ipi) | (k & ~(m_ipi | s))) != 0) ? 1 : 0;
    e_err  = er ? 1 : 0;
    if (v && !w) begin
      e_rdv = 1;
      case (a)
        0: e_rdd = (m_ipi << 8) | (m_tmr << 4) | c;
        1: e_rdd = m_ipi;
        2: e_rdd = m_tmr;
        default: e_rdd = 0;
      endcase
    end
    m_ipi = (m_ipi | s) & ~k;
    m_tmr = m_tmr & ~tk;
    if (t) m_tmr = PMASK;
    e_ipi = m_ipi; e_tmr = m_tmr;
    e_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0;
    req_wdata = 0; req_cpu = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    step("R8", 1, 0, 0, 0, 2, 0);          // reset read of control
    idle("R1");
    step("R2", 1, 1, 0, 32'h0000_5000, 0, 0); // post cpus 0 and 2
    step("R8", 1, 0, 1, 0, 0, 0);
    step("R6", 1, 1, 0, 32'h0000_1000, 0, 0); // repost cpu0 -> warn
    step("R3", 1, 1, 0, 32'h0000_0100, 0, 0); // clear cpu0
    step("R6", 1, 1, 1, 32'h1, 0, 0);          // clear idle cpu0 -> warn
    step("R3", 1, 1, 0, 32'h0000_2200, 0, 0); // req+clr cpu1 -> clr wins
    step("R5", 0, 0, 0, 0, 0, 1);              // tick
    step("R8", 1, 0, 2, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 1, 0);
    step("R3", 1, 1, 0, 32'h0000_0020, 0, 0); // clear timer cpu1
    step("R4", 1, 1, 2, 32'h4, 0, 0);          // clear timer cpu2
    step("R5", 1, 1, 2, 32'h1, 0, 1);          // tick wins over clear
    step("R4", 1, 1, 3, 32'h3, 0, 0);          // request cpus 0,1
    step("R4", 1, 1, 1, 32'h5, 0, 0);          // clear cpus 0,2
    step("R7", 1, 1, 0, 32'h0000_0000, 0, 0); // empty control
    step("R7", 1, 1, 0, 32'h1000_0000, 0, 0); // bit 28 only, no error
    step("R7", 1, 1, 3, 32'hF0, 0, 0);         // zero mask request
    step("R7", 1, 1, 1, 32'h0, 0, 0);
    step("R7", 1, 1, 2, 32'h0, 0, 0);
    step("R9", 1, 1, 3, 32'h8, 0, 0);          // absent cpu3 only
    step("R9", 1, 1, 0, 32'h0000_8880, 0, 0); // absent bits in all fields
    step("R8", 1, 0, 3, 0, 3, 0);
    step("R8", 1, 0, 0, 0, 3, 0);
    step("R2", 1, 1, 0, 32'h0000_7000, 0, 0); // post all, cpu1 pending -> warn
    step("R8", 1, 0, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++)
      step("R6", 1, 1, (i % 2 == 0) ? 3 : 1, (i * 5 + 1) & 7, 0, (i % 7) == 3);
    idle("R8");
    idle("R1");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule